// File: doc/BRIEF.md
# Register File Write-Port Router

This block connects a large set of result producers to a register file that has only a small number of write ports. Each producer owns a short queue inside the router. A result enters that queue in the cycle the producer presents it. The producer does not have to wait for a free write port. In every clock, the router takes queued results from as many non-empty queues as there are write ports and drives them onto the ports.

Results that carry no register destination, such as those from stores and branches, are accepted and discarded. They never occupy a queue slot or a port, and they delay no other producer. When more producers are pending than there are ports, the surplus waits in its queues. Draining then takes one extra clock for each further group of port-count results.

Top module: `wpr_router`

## Requirements
- R1: After reset, every port write enable is low and every source ready output is high.
- R2: When a single cycle brings register-writing results from one to four sources into empty queues, all of them appear on the ports in one clock, two rising edges after they were presented.
- R3: When five to eight sources become pending together, they drain over exactly two consecutive clocks, the second being the one extra clock.
- R4: When nine to twelve sources become pending together, they drain over exactly three consecutive clocks, two extra clocks beyond the first.
- R5: Ports are granted by fixed priority, lowest source index first. Among the sources served in a clock, port 0 carries the lowest index, port 1 the next, and so on.
- R6: Results from one source reach the ports in the order in which that source presented them.
- R7: A result presented with valid high and its write flag low takes no queue slot and no port, and it does not delay any writing result presented in the same cycle.
- R8: Each source queue holds four results. While it holds four, the source's ready output is low, and a result presented then is dropped and never written.
- R9: The ports in use in a clock are always a contiguous group starting at port 0. Every other port has its write enable low.
- R10: A written result carries on its port exactly the register index and data with which its source presented it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NSRC | Per-source result valid |
| src_wr | input | NSRC | Per-source flag: result writes a register |
| src_tag | input | NSRC*TAGW | Per-source destination register index, source s at bits [s*TAGW +: TAGW] |
| src_data | input | NSRC*DATAW | Per-source result data, source s at bits [s*DATAW +: DATAW] |
| src_ready | output | NSRC | Per-source queue not full |
| port_we | output | NPORT | Per-port write enable |
| port_tag | output | NPORT*TAGW | Per-port register index, port p at bits [p*TAGW +: TAGW] |
| port_data | output | NPORT*DATAW | Per-port write data, port p at bits [p*DATAW +: DATAW] |

## Verification
The bench builds the router with twelve sources, four ports and four-deep queues, which are the defaults, and with a 32-bit data path and 6-bit register index. At these values, batches of 1, 4, 6, 8, 9 and 12 simultaneous producers reach the one-, two- and three-clock drain cases, including the exact boundaries at four and eight. Twelve sources against four ports also allow four always-busy low-index producers to starve a higher one. That higher source's queue then fills to its depth, which exercises the full, ready-low and dropped-push cases and shows that the stored results later leave in their original order.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    localparam int WPR_NSRC_DEF  = 12;
    localparam int WPR_NPORT_DEF = 4;
    localparam int WPR_DEPTH_DEF = 4;
    localparam int WPR_TAGW_DEF  = 6;
    localparam int WPR_DATAW_DEF = 64;
endpackage

// File: rtl/wpr_srcq.sv
module wpr_srcq #(
    parameter int DEPTH = 4,
    parameter int W     = 70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_item,
    input  logic         pop,
    output logic         empty,
    output logic         full,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } qstate_t;

    qstate_t st_d, st_q;
    logic    take_d, give_d;

    always_comb begin
        st_d   = st_q;
        take_d = push && (st_q.cnt != CW'(DEPTH));
        give_d = pop && (st_q.cnt != '0);
        if (take_d) begin
            st_d.mem[st_q.wr] = push_item;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (give_d) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({take_d, give_d})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign head  = st_q.mem[st_q.rd];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R5
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !empty) |=> $stable(head));
endmodule

// File: rtl/wpr_pick.sv
module wpr_pick #(
    parameter int NSRC  = 12,
    parameter int NPORT = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSRC-1:0]                req,
    output logic [NSRC-1:0]                gnt,
    output logic [NPORT-1:0]               port_vld,
    output logic [NPORT-1:0][$clog2(NSRC)-1:0] port_sel
);
    localparam int SW = $clog2(NSRC);
    localparam int KW = $clog2(NPORT + 1);

    logic [KW-1:0] used_d;

    always_comb begin
        gnt      = '0;
        port_vld = '0;
        port_sel = '0;
        used_d   = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (used_d != KW'(NPORT))) begin
                gnt[s]           = 1'b1;
                port_vld[used_d] = 1'b1;
                port_sel[used_d] = SW'(s);
                used_d           = used_d + 1'b1;
            end
        end
    end

    // R9
    port_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_vld + NPORT'(1)) & port_vld) == '0);
    // R5
    grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) == $countones(port_vld));
    // R5
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R5
    full_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) >= NPORT) |-> (&port_vld));
endmodule

// File: rtl/wpr_router.sv
module wpr_router
    import wpr_pkg::*;
#(
    parameter int NSRC  = WPR_NSRC_DEF,
    parameter int NPORT = WPR_NPORT_DEF,
    parameter int DEPTH = WPR_DEPTH_DEF,
    parameter int TAGW  = WPR_TAGW_DEF,
    parameter int DATAW = WPR_DATAW_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC-1:0]        src_wr,
    input  logic [NSRC*TAGW-1:0]   src_tag,
    input  logic [NSRC*DATAW-1:0]  src_data,
    output logic [NSRC-1:0]        src_ready,
    output logic [NPORT-1:0]       port_we,
    output logic [NPORT*TAGW-1:0]  port_tag,
    output logic [NPORT*DATAW-1:0] port_data
);
    localparam int W  = TAGW + DATAW;
    localparam int SW = $clog2(NSRC);

    typedef struct packed {
        logic [NPORT-1:0]       we;
        logic [NPORT*TAGW-1:0]  tag;
        logic [NPORT*DATAW-1:0] data;
    } wport_t;

    logic [NSRC-1:0]               q_empty;
    logic [NSRC-1:0]               q_full;
    logic [NSRC-1:0]               q_pop;
    logic [NSRC-1:0][W-1:0]        q_head;
    logic [NPORT-1:0]              sel_vld;
    logic [NPORT-1:0][SW-1:0]      sel_src;
    wport_t                        out_d, out_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        wpr_srcq #(.DEPTH(DEPTH), .W(W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (src_valid[s] & src_wr[s]),
            .push_item ({src_tag[s*TAGW +: TAGW], src_data[s*DATAW +: DATAW]}),
            .pop       (q_pop[s]),
            .empty     (q_empty[s]),
            .full      (q_full[s]),
            .head      (q_head[s])
        );
    end

    assign src_ready = ~q_full;

    wpr_pick #(.NSRC(NSRC), .NPORT(NPORT)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (~q_empty),
        .gnt      (q_pop),
        .port_vld (sel_vld),
        .port_sel (sel_src)
    );

    always_comb begin
        out_d    = '0;
        out_d.we = sel_vld;
        for (int p = 0; p < NPORT; p++) begin
            if (sel_vld[p]) begin
                out_d.tag[p*TAGW +: TAGW]    = q_head[sel_src[p]][W-1 -: TAGW];
                out_d.data[p*DATAW +: DATAW] = q_head[sel_src[p]][DATAW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign port_we   = out_q.we;
    assign port_tag  = out_q.tag;
    assign port_data = out_q.data;

    // R2
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~q_empty)) |=> (|port_we));
    // R9
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty == '1) |=> (port_we == '0));
endmodule

// File: tb/sim_wpr_router.sv
module sim_wpr_router;
    localparam int NSRC  = 12;
    localparam int NPORT = 4;
    localparam int DEPTH = 4;
    localparam int TAGW  = 6;
    localparam int DATAW = 32;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NSRC-1:0]        src_valid = '0;
    logic [NSRC-1:0]        src_wr = '0;
    logic [NSRC*TAGW-1:0]   src_tag = '0;
    logic [NSRC*DATAW-1:0]  src_data = '0;
    logic [NSRC-1:0]        src_ready;
    logic [NPORT-1:0]       port_we;
    logic [NPORT*TAGW-1:0]  port_tag;
    logic [NPORT*DATAW-1:0] port_data;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    wpr_router #(.NSRC(NSRC), .NPORT(NPORT), .DEPTH(DEPTH), .TAGW(TAGW), .DATAW(DATAW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_wr(src_wr),
        .src_tag(src_tag), .src_data(src_data), .src_ready(src_ready),
        .port_we(port_we), .port_tag(port_tag), .port_data(port_data)
    );

    function automatic logic [TAGW-1:0] tag_of(int s);
        return TAGW'(s + 40);
    endfunction

    function automatic logic [DATAW-1:0] data_of(int s, int seq);
        return {8'(s), 8'(seq), 16'hC0DE};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_src(int s, bit v, bit w, int seq);
        src_valid[s] = v;
        src_wr[s]    = w;
        src_tag[s*TAGW +: TAGW]    = tag_of(s);
        src_data[s*DATAW +: DATAW] = data_of(s, seq);
    endtask

    // One batch presented in a single cycle, checked cycle by cycle (R2 R3 R4 R5 R7 R9 R10)
    task automatic run_batch(input logic [NSRC-1:0] vmask, input logic [NSRC-1:0] wmask, input int seq);
        int order[NSRC];
        int n = 0;
        int ncyc;
        string rq;
        for (int s = 0; s < NSRC; s++)
            if (vmask[s] && wmask[s]) begin order[n] = s; n++; end
        ncyc = (n + NPORT - 1) / NPORT;
        if (vmask != wmask) rq = "R7";
        else if (n <= 4)    rq = "R2";
        else if (n <= 8)    rq = "R3";
        else                rq = "R4";
        @(negedge clk);
        for (int s = 0; s < NSRC; s++) set_src(s, vmask[s], wmask[s], seq);
        @(negedge clk);
        src_valid = '0;
        chk(port_we == '0, "R9", 64'(port_we), 64'd0);
        for (int c = 0; c <= ncyc; c++) begin
            @(negedge clk);
            for (int p = 0; p < NPORT; p++) begin
                int idx = c * NPORT + p;
                if (idx < n) begin
                    chk(port_we[p] == 1'b1, rq, 64'(port_we), 64'(p));
                    chk(port_tag[p*TAGW +: TAGW] == tag_of(order[idx]), "R5",
                        64'(port_tag[p*TAGW +: TAGW]), 64'(tag_of(order[idx])));
                    chk(port_data[p*DATAW +: DATAW] == data_of(order[idx], seq), "R10",
                        64'(port_data[p*DATAW +: DATAW]), 64'(data_of(order[idx], seq)));
                end else begin
                    chk(port_we[p] == 1'b0, (c < ncyc) ? "R9" : rq, 64'(port_we), 64'd0);
                end
            end
        end
    endtask

    // Source 5 starved by sources 0..3, fills, drops a push, then drains in order (R6 R8)
    task automatic run_fill();
        int got[8];
        int ng = 0;
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            for (int s = 0; s < 4; s++) set_src(s, 1'b1, 1'b1, 100 + k);
            set_src(5, 1'b1, 1'b1, k);
        end
        @(negedge clk);
        chk(src_ready[5] == 1'b0, "R8", 64'(src_ready), 64'd0);
        chk(src_ready[4] == 1'b1, "R8", 64'(src_ready), 64'd1);
        for (int s = 0; s < 4; s++) set_src(s, 1'b1, 1'b1, 120);
        set_src(5, 1'b1, 1'b1, 9);
        @(negedge clk);
        src_valid = '0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            for (int p = 0; p < NPORT; p++)
                if (port_we[p] && port_data[p*DATAW+24 +: 8] == 8'd5 && ng < 8) begin
                    got[ng] = int'(port_data[p*DATAW+16 +: 8]);
                    ng++;
                end
        end
        chk(ng == DEPTH, "R8", 64'(ng), 64'(DEPTH));
        for (int k = 0; k < DEPTH; k++)
            if (k < ng) chk(got[k] == k, "R6", 64'(got[k]), 64'(k));
        chk(src_ready == '1, "R8", 64'(src_ready), 64'hFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(port_we == '0, "R1", 64'(port_we), 64'd0);
        chk(src_ready == '1, "R1", 64'(src_ready), 64'hFFF);
        run_batch(12'h800, 12'hFFF, 1);
        run_batch(12'h00F, 12'hFFF, 2);
        run_batch(12'h0A5, 12'hFFF, 3);
        run_batch(12'h3F0, 12'hFFF, 4);
        run_batch(12'h0FF, 12'hFFF, 5);
        run_batch(12'h1FF, 12'hFFF, 6);
        run_batch(12'hFFF, 12'hFFF, 7);
        run_batch(12'hFFF, 12'hA5A, 8);
        run_batch(12'hFFF, 12'h000, 9);
        run_fill();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule